// File: doc/BRIEF.md
# Shared-Operand Dual Signed Byte Multiplier

This block forms two signed 8-bit by 8-bit products that have one factor in common, `x*w` and `y*w`, with a single wide signed multiply rather than two narrow ones. The two private factors are merged into one 27-bit word. `x` sits above a fixed 18-bit gap and `y`, sign-extended, fills the low field. This word is multiplied by the shared factor `w`, which is sign-extended to 18 bits. Both 16-bit products are then read back out of the 45-bit result.

A negative low product borrows one unit from the upper field of the wide result. The extraction stage detects that borrow from the top bit of the low field and adds it back. This makes the upper lane exact for every operand combination.

The path is three register stages: merge, multiply, split. A valid bit travels alongside the data and takes a new operand set on every clock. A stage that receives no valid keeps its previous contents.

Top module: `dual_mul8_shared`

## Requirements
- R1: While reset is held low, and after its release until the first valid result, `out_vld` is 0 and both `out_hi` and `out_lo` are 0.
- R2: `out_lo` equals the signed product `y*w`, in 16-bit two's complement.
- R3: `out_hi` equals the signed product `x*w`, in 16-bit two's complement.
- R4: `out_hi` is exact even when `y*w` is negative. The borrow that a negative low product causes in the upper field of the wide result is corrected.
- R5: An operand set presented with `in_vld` high on a rising edge appears at the outputs, with `out_vld` high, after the third rising edge counted from that one. Operand sets on consecutive cycles give results on consecutive cycles.
- R6: The extreme operands give exact results in both lanes: -128*-128 = 16384 and -128*127 = -16256.
- R7: A cycle with `in_vld` low produces a cycle with `out_vld` low three edges later. During that cycle `out_hi` and `out_lo` keep the last valid products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operand set on this cycle is valid |
| in_x | input | 8 | Upper-lane private factor, signed |
| in_y | input | 8 | Lower-lane private factor, signed |
| in_w | input | 8 | Shared factor, signed |
| out_vld | output | 1 | Products on this cycle are valid |
| out_hi | output | 16 | Product x*w, signed |
| out_lo | output | 16 | Product y*w, signed |

## Verification
The first pattern sweeps every combination of `x` and `w` exhaustively, with a random `y`. This exercises the upper lane against all shared values, and about half of its cycles carry a negative low product, so it tells a correct borrow fix apart from a missing or inverted one. Random operand sets with random gaps in `in_vld` separate correct latency and hold behaviour from an off-by-one stage or a register that updates without valid. Directed sets pair the extreme values -128 and 127 in each lane. These catch truncation or sign-extension errors that random values rarely reach.

// File: rtl/dm_pkg.sv
package dm_pkg;
    localparam int OPW   = 8;              // operand width
    localparam int GAP   = 18;             // bit offset of the upper lane
    localparam int AW    = 27;             // wide multiplier port A
    localparam int CW    = 18;             // wide multiplier port B
    localparam int PW    = AW + CW;        // full product width
    localparam int LW    = 2 * OPW;        // lane product width
endpackage

// File: rtl/dm_pack.sv
module dm_pack
    import dm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vld_i,
    input  logic signed [OPW-1:0] x_i,
    input  logic signed [OPW-1:0] y_i,
    input  logic signed [OPW-1:0] w_i,
    output logic                  vld_o,
    output logic        [AW-1:0]  word_o,
    output logic        [CW-1:0]  wext_o
);
    localparam int XPAD = AW - OPW - GAP;
    localparam int YPAD = AW - OPW;
    localparam int WPAD = CW - OPW;

    logic [AW-1:0] x_field;
    logic [AW-1:0] y_field;

    always_comb begin
        x_field = {{XPAD{x_i[OPW-1]}}, x_i, {GAP{1'b0}}};
        y_field = {{YPAD{y_i[OPW-1]}}, y_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            word_o <= '0;
            wext_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                word_o <= x_field + y_field;
                wext_o <= {{WPAD{w_i[OPW-1]}}, w_i};
            end
        end
    end

    a_r7_pack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(word_o) && $stable(wext_o));
endmodule

// File: rtl/dm_wide_mul.sv
module dm_wide_mul
    import dm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [AW-1:0]     word_i,
    input  logic [CW-1:0]     wext_i,
    output logic              vld_o,
    output logic [PW-1:0]     prod_o
);
    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] full;

    always_comb begin
        a_ext = {{CW{word_i[AW-1]}}, word_i};
        b_ext = {{AW{wext_i[CW-1]}}, wext_i};
        full  = a_ext * b_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            prod_o <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) prod_o <= full;
        end
    end

    a_r5_stage2_follows: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);
    a_r7_mul_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(prod_o));
endmodule

// File: rtl/dm_split.sv
module dm_split
    import dm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [PW-1:0]     prod_i,
    output logic              vld_o,
    output logic [LW-1:0]     hi_o,
    output logic [LW-1:0]     lo_o
);
    logic [LW-1:0] hi_raw;
    logic [LW-1:0] borrow;

    always_comb begin
        hi_raw = prod_i[GAP+LW-1:GAP];
        borrow = {{(LW-1){1'b0}}, prod_i[GAP-1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o <= 1'b0;
            hi_o  <= '0;
            lo_o  <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                lo_o <= prod_i[LW-1:0];
                hi_o <= hi_raw + borrow;
            end
        end
    end

    a_r5_stage3_follows: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);
    a_r6_lo_range: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> ($signed(lo_o) >= -16'sd16256 && $signed(lo_o) <= 16'sd16384));
    a_r6_hi_range: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> ($signed(hi_o) >= -16'sd16256 && $signed(hi_o) <= 16'sd16384));
endmodule

// File: rtl/dual_mul8_shared.sv
module dual_mul8_shared
    import dm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic [7:0]  in_x,
    input  logic [7:0]  in_y,
    input  logic [7:0]  in_w,
    output logic        out_vld,
    output logic [15:0] out_hi,
    output logic [15:0] out_lo
);
    logic          v1;
    logic [AW-1:0] word1;
    logic [CW-1:0] wext1;
    logic          v2;
    logic [PW-1:0] prod2;

    dm_pack u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_vld),
        .x_i    (in_x),
        .y_i    (in_y),
        .w_i    (in_w),
        .vld_o  (v1),
        .word_o (word1),
        .wext_o (wext1)
    );

    dm_wide_mul u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (v1),
        .word_i (word1),
        .wext_i (wext1),
        .vld_o  (v2),
        .prod_o (prod2)
    );

    dm_split u_split (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (v2),
        .prod_i (prod2),
        .vld_o  (out_vld),
        .hi_o   (out_hi),
        .lo_o   (out_lo)
    );

    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !v2 |=> !out_vld && $stable(out_hi) && $stable(out_lo));
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !out_vld && out_hi == 16'd0 && out_lo == 16'd0);
endmodule

// File: tb/tb_dual_mul8_shared.sv
`timescale 1ns/1ps
module tb_dual_mul8_shared;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [7:0]  in_x = '0;
    logic [7:0]  in_y = '0;
    logic [7:0]  in_w = '0;
    logic        out_vld;
    logic [15:0] out_hi;
    logic [15:0] out_lo;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic        h_v [0:2];
    logic [7:0]  h_x [0:2];
    logic [7:0]  h_y [0:2];
    logic [7:0]  h_w [0:2];
    logic [15:0] last_hi = '0;
    logic [15:0] last_lo = '0;

    always #2.5 clk = ~clk;

    dual_mul8_shared dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .in_x(in_x), .in_y(in_y), .in_w(in_w),
        .out_vld(out_vld), .out_hi(out_hi), .out_lo(out_lo)
    );

    function automatic logic [15:0] ref_mul(input logic [7:0] p, input logic [7:0] q);
        int sp;
        int sq;
        sp = (p > 8'd127) ? int'(p) - 256 : int'(p);
        sq = (q > 8'd127) ? int'(q) - 256 : int'(q);
        return 16'(sp * sq);
    endfunction

    function automatic bit is_corner(input logic [7:0] p, input logic [7:0] q);
        return (p == 8'h80) && (q == 8'h80 || q == 8'h7f);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] x, input logic [7:0] y, input logic [7:0] w);
        logic [15:0] eh;
        logic [15:0] el;
        @(negedge clk);
        check("R5 out_vld timing", {15'd0, out_vld}, {15'd0, h_v[2]});
        if (h_v[2]) begin
            eh = ref_mul(h_x[2], h_w[2]);
            el = ref_mul(h_y[2], h_w[2]);
            if (is_corner(h_x[2], h_w[2]) || is_corner(h_w[2], h_x[2]))
                check("R6 hi corner", out_hi, eh);
            else if (el[15])
                check("R4 hi with borrow", out_hi, eh);
            else
                check("R3 hi", out_hi, eh);
            if (is_corner(h_y[2], h_w[2]) || is_corner(h_w[2], h_y[2]))
                check("R6 lo corner", out_lo, el);
            else
                check("R2 lo", out_lo, el);
            last_hi = eh;
            last_lo = el;
        end else begin
            check("R7 hi hold", out_hi, last_hi);
            check("R7 lo hold", out_lo, last_lo);
        end
        for (int i = 2; i > 0; i--) begin
            h_v[i] = h_v[i-1]; h_x[i] = h_x[i-1];
            h_y[i] = h_y[i-1]; h_w[i] = h_w[i-1];
        end
        h_v[0] = v; h_x[0] = x; h_y[0] = y; h_w[0] = w;
        in_vld = v; in_x = x; in_y = y; in_w = w;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin
            h_v[i] = 1'b0; h_x[i] = '0; h_y[i] = '0; h_w[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is held
        check("R1 vld in reset", {15'd0, out_vld}, 16'd0);
        check("R1 hi in reset", out_hi, 16'd0);
        check("R1 lo in reset", out_lo, 16'd0);
        rst_n = 1'b1;
        // R1: stays cleared after release with no valid input
        repeat (4) step(1'b0, 8'h55, 8'haa, 8'h33);
        // R6: directed corners in each lane
        step(1'b1, 8'h80, 8'h80, 8'h80);
        step(1'b1, 8'h80, 8'h7f, 8'h80);
        step(1'b1, 8'h7f, 8'h80, 8'h80);
        step(1'b1, 8'h80, 8'h80, 8'h7f);
        step(1'b1, 8'h7f, 8'h7f, 8'h7f);
        step(1'b1, 8'h00, 8'hff, 8'h01);
        step(1'b0, 8'h12, 8'h34, 8'h56);
        // R2 R3 R4: exhaustive x and w, random y, back to back (R5)
        for (int a = 0; a < 256; a++)
            for (int c = 0; c < 256; c++)
                step(1'b1, 8'(a), 8'($urandom), 8'(c));
        // R5 R7: random operands with random gaps
        for (int k = 0; k < 20000; k++)
            step(($urandom % 3) != 0, 8'($urandom), 8'($urandom), 8'($urandom));
        repeat (4) step(1'b0, 8'h00, 8'h00, 8'h00);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule